// File: doc/BRIEF.md
# Serial Bus Pause Gate

This block sits between the synchronised pins of a serial peripheral bus and the slave's shift controller. It gives the bus master a way to freeze a transfer part-way through with an active-low pause input. While the pause is in force, the block hides clock edges and input-data changes from the controller. The controller's bit counter and shift register therefore stay exactly as they were, and the transfer resumes from that bit once the pause ends.

The controller never looks at the raw clock. It sees only the block's gated rising and falling clock strobes, together with a data bit that is held steady during a pause. The block also drives an override that puts the serial output in high impedance as soon as the pause pin goes low. The pause can only start or end while the serial clock is low:

- A pause request that arrives with the clock high waits for the next clock falling edge. That edge is swallowed.
- A release that arrives with the clock high is refused.

Chip select stays fully in charge. Deselecting the device ends a pause.

All inputs are sampled in the `clk` domain. Clock edges are found by comparing each sample with the one before.

Top module: `hold_gate`

## Requirements
- R1: After reset, `pauseActive` is 0. `soForceHiZ` is 0 while `holdN` is 1. No gated strobe is raised while `sck` stays at 0.
- R2: If `holdN` falls (sampled 1 then 0) while `csN` is 0 and `sck` is sampled 0, then `pauseActive` reads 1 from the next cycle. Both gated strobes are held at 0 from the cycle in which the fall is seen.
- R3: If `holdN` falls while `sck` is sampled 1, the pause is deferred. It takes effect on the next `sck` falling edge: that edge gives no `sckFallGated` pulse, and `pauseActive` reads 1 from the following cycle.
- R4: While paused, `sck` and `si` activity is ignored. No gated strobe pulses, and `siGated` keeps the last `si` value the controller saw before the pause.
- R5: A `holdN` rise while paused, with `sck` sampled 0, clears `pauseActive` from the next cycle. Later `sck` edges pass again, so the controller continues from the bit where it stopped.
- R6: A `holdN` rise while paused with `sck` sampled 1 is refused. The block stays paused even after `sck` returns low. Only a later `holdN` fall followed by a rise with `sck` low resumes it.
- R7: `soForceHiZ` is 1 in the same cycle that `holdN` is sampled 0, whether or not the pause has taken effect. It stays 1 for as long as `pauseActive` is 1, including after a refused release.
- R8: `csN` sampled 1 clears any pause or deferred pause by the next cycle. A `holdN` fall seen while `csN` is 1 starts no pause.
- R9: A `holdN` rise seen before a deferred pause has taken effect cancels that pause. The next `sck` falling edge is then passed through.
- R10: A gated strobe is raised in the same cycle that `sck` is first sampled at its new level (rising: 0 then 1; falling: 1 then 0), unless masked by R2 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Synchronised chip select, active low |
| sck | input | 1 | Synchronised serial clock level |
| si | input | 1 | Synchronised serial data in |
| holdN | input | 1 | Synchronised pause request, active low |
| sckRiseGated | output | 1 | One-cycle strobe for a passed rising serial clock edge |
| sckFallGated | output | 1 | One-cycle strobe for a passed falling serial clock edge |
| siGated | output | 1 | Serial data for the controller, frozen while paused |
| pauseActive | output | 1 | Pause in force |
| soForceHiZ | output | 1 | Forces the serial output driver to high impedance |

## Verification
The gated strobes, `siGated` and `soForceHiZ` are combinational from the current samples and are due in the same cycle as the input change that causes them. `pauseActive` is registered and changes one cycle after the qualifying pause-pin or clock edge. The bench changes the inputs on the falling edge of `clk` and compares every output 1 ns later, before the next rising edge. Its behavioural model then advances one step, so each same-cycle result and each next-cycle result is checked in the cycle it is due.

// File: rtl/hold_pkg.sv
package hold_pkg;
  // command bundle passed from the pause control to the datapath
  typedef struct packed {
    logic mask;    // suppress edges and freeze data this cycle
    logic paused;  // registered pause state
  } holdCmd_t;
endpackage

// File: rtl/hold_ctrl.sv
module hold_ctrl
  import hold_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     csN,
  input  logic     holdN,
  input  logic     sckLevel,
  input  logic     sckFall,
  output holdCmd_t cmd
);
  logic holdPrev;
  logic pausedQ;
  logic pendQ;
  logic holdFall;
  logic holdRise;
  logic selected;
  logic enterNow;
  logic leaveNow;
  logic pendNext;
  logic pausedNext;

  assign holdFall = holdPrev & ~holdN;
  assign holdRise = ~holdPrev & holdN;
  assign selected = ~csN;

  // entry happens only with the clock low: direct, or deferred to a fall
  assign enterNow = selected & ((holdFall & ~sckLevel) | (pendQ & sckFall & ~holdN));
  assign leaveNow = pausedQ & holdRise & ~sckLevel;
  assign pendNext = selected & ~holdN & ~enterNow & (pendQ | (holdFall & sckLevel));

  always_comb begin
    if (!selected)     pausedNext = 1'b0;
    else if (enterNow) pausedNext = 1'b1;
    else if (leaveNow) pausedNext = 1'b0;
    else               pausedNext = pausedQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdPrev <= 1'b1;
      pausedQ  <= 1'b0;
      pendQ    <= 1'b0;
    end else begin
      holdPrev <= holdN;
      pausedQ  <= pausedNext;
      pendQ    <= pendNext;
    end
  end

  assign cmd.mask   = pausedQ | enterNow;
  assign cmd.paused = pausedQ;

  // R2, R3: a pause only ever starts from a cycle with the clock sampled low
  assert_entry_sck_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pausedQ) |-> !$past(sckLevel));

  // R5, R8: a pause ends only with the clock low or on deselect
  assert_exit_sck_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pausedQ) |-> (!$past(sckLevel) || $past(csN)));

  // R6: a release seen with the clock high keeps the pause
  assert_refused_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pausedQ && !csN && sckLevel && $rose(holdN)) |=> pausedQ);

  // R3: a deferred pause takes effect on the clock fall
  assert_deferred_entry_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ && sckFall && !holdN && !csN) |=> pausedQ);

  // R8: deselect clears the pause
  assert_deselect_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !pausedQ);
endmodule

// File: rtl/hold_datapath.sv
module hold_datapath
  import hold_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     sck,
  input  logic     si,
  input  logic     holdN,
  input  holdCmd_t cmd,
  output logic     sckFall,
  output logic     sckRiseOut,
  output logic     sckFallOut,
  output logic     siOut,
  output logic     soHiZ
);
  logic sckPrev;
  logic siLast;
  logic sckRise;

  assign sckRise = sck & ~sckPrev;
  assign sckFall = ~sck & sckPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev <= 1'b0;
      siLast  <= 1'b0;
    end else begin
      sckPrev <= sck;
      if (!cmd.mask) siLast <= si;
    end
  end

  assign sckRiseOut = sckRise & ~cmd.mask;
  assign sckFallOut = sckFall & ~cmd.mask;
  assign siOut      = cmd.mask ? siLast : si;
  assign soHiZ      = ~holdN | cmd.paused;

  // R4: data seen by the controller stays frozen across a masked span
  assert_si_frozen_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.mask && $past(cmd.mask)) |-> $stable(siOut));
endmodule

// File: rtl/hold_gate.sv
module hold_gate
  import hold_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic si,
  input  logic holdN,
  output logic sckRiseGated,
  output logic sckFallGated,
  output logic siGated,
  output logic pauseActive,
  output logic soForceHiZ
);
  holdCmd_t cmd;
  logic     sckFall;

  hold_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (csN),
    .holdN    (holdN),
    .sckLevel (sck),
    .sckFall  (sckFall),
    .cmd      (cmd)
  );

  hold_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sck        (sck),
    .si         (si),
    .holdN      (holdN),
    .cmd        (cmd),
    .sckFall    (sckFall),
    .sckRiseOut (sckRiseGated),
    .sckFallOut (sckFallGated),
    .siOut      (siGated),
    .soHiZ      (soForceHiZ)
  );

  assign pauseActive = cmd.paused;

  // R4: no strobe reaches the controller while paused
  assert_no_strobe_paused_R4: assert property (@(posedge clk) disable iff (!rstN)
    pauseActive |-> (!sckRiseGated && !sckFallGated));

  // R7: output stays high impedance for the whole pause
  assert_hiz_paused_R7: assert property (@(posedge clk) disable iff (!rstN)
    pauseActive |-> soForceHiZ);
endmodule

// File: tb/sim_hold_gate.sv
`timescale 1ns/1ps
module sim_hold_gate;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sck = 1'b0;
  logic si = 1'b0;
  logic holdN = 1'b1;
  logic sckRiseGated, sckFallGated, siGated, pauseActive, soForceHiZ;

  int checks = 0;
  int fails = 0;
  string curReq = "R1";

  // behavioural reference state
  int mSckPrev = 0, mHoldPrev = 1, mPaused = 0, mPend = 0, mSiLast = 0;
  int riseCount = 0;

  always #2.5 clk = ~clk;

  hold_gate u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .holdN(holdN),
    .sckRiseGated(sckRiseGated), .sckFallGated(sckFallGated), .siGated(siGated),
    .pauseActive(pauseActive), .soForceHiZ(soForceHiZ)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // one sampling clock: drive, compare against the model, advance the model
  task automatic tick(input int s, input int d, input int h, input int c);
    int rise, fall, hFall, hRise, enter, gate;
    @(negedge clk);
    sck = s[0]; si = d[0]; holdN = h[0]; csN = c[0];
    #1;
    rise  = (s == 1 && mSckPrev == 0);
    fall  = (s == 0 && mSckPrev == 1);
    hFall = (h == 0 && mHoldPrev == 1);
    hRise = (h == 1 && mHoldPrev == 0);
    enter = 0;
    if (c == 0) begin
      if (hFall && s == 0) enter = 1;
      if (mPend && fall && h == 0) enter = 1;
    end
    gate = mPaused || enter;
    check(curReq, "sckRiseGated", sckRiseGated, (rise && !gate));
    check(curReq, "sckFallGated", sckFallGated, (fall && !gate));
    check(curReq, "siGated", siGated, gate ? mSiLast : d);
    check(curReq, "pauseActive", pauseActive, mPaused);
    check(curReq, "soForceHiZ", soForceHiZ, (h == 0 || mPaused));
    if (sckRiseGated) riseCount++;
    // model advance
    if (c == 1) begin
      mPaused = 0; mPend = 0;
    end else begin
      if (enter) begin
        mPaused = 1; mPend = 0;
      end else begin
        if (mPaused && hRise && s == 0) mPaused = 0;
        if (h == 1) mPend = 0;
        else if (hFall && s == 1) mPend = 1;
      end
    end
    if (!gate) mSiLast = d;
    mSckPrev = s; mHoldPrev = h;
  endtask

  // one serial bit: clock low then high, data set up while low
  task automatic bitOut(input int d, input int h);
    tick(0, d, h, 0);
    tick(1, d, h, 0);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    #1;
    check("R1", "pauseActive in reset", pauseActive, 0);
    check("R1", "soForceHiZ in reset", soForceHiZ, 0);
    @(negedge clk); rstN = 1'b1;
    curReq = "R1";
    tick(0, 0, 1, 1);
    tick(0, 0, 1, 1);

    // R10 / R2 / R4 / R5: four bits, pause with clock low, wiggle, resume, four bits
    curReq = "R10";
    riseCount = 0;
    tick(0, 0, 1, 0);
    bitOut(1, 1); bitOut(0, 1); bitOut(1, 1); bitOut(1, 1);
    curReq = "R2";
    tick(0, 1, 0, 0);
    check("R2", "pauseActive after clock-low hold fall", pauseActive, 0);
    tick(0, 0, 0, 0);
    check("R2", "pauseActive one cycle later", pauseActive, 1);
    curReq = "R4";
    for (int i = 0; i < 3; i++) begin
      tick(1, i & 1, 0, 0);
      tick(0, ~i & 1, 0, 0);
    end
    check("R4", "siGated frozen at last bit", siGated, 1);
    curReq = "R5";
    tick(0, 0, 1, 0);
    tick(0, 0, 1, 0);
    check("R5", "pauseActive after release", pauseActive, 0);
    bitOut(0, 1); bitOut(1, 1); bitOut(0, 1); bitOut(1, 1);
    check("R5", "rising strobes across pause", riseCount, 8);

    // R3: hold falls while clock high, deferred to next fall
    curReq = "R3";
    tick(1, 0, 1, 0);
    tick(1, 0, 0, 0);
    check("R3", "not yet paused with clock high", pauseActive, 0);
    check("R7", "hiZ on hold low before pause", soForceHiZ, 1);
    tick(0, 0, 0, 0);
    check("R3", "deferred fall swallowed", sckFallGated, 0);
    tick(0, 0, 0, 0);
    check("R3", "paused after deferred fall", pauseActive, 1);

    // R6: release refused with clock high
    curReq = "R6";
    tick(1, 1, 0, 0);
    tick(1, 1, 1, 0);
    tick(0, 1, 1, 0);
    tick(0, 1, 1, 0);
    check("R6", "still paused after refused release", pauseActive, 1);
    check("R7", "hiZ held after refused release", soForceHiZ, 1);
    bitOut(0, 1);
    tick(0, 0, 0, 0);
    tick(0, 0, 1, 0);
    tick(0, 0, 1, 0);
    check("R6", "resumed after fresh hold cycle", pauseActive, 0);

    // R9: deferred pause cancelled by release before the fall
    curReq = "R9";
    tick(1, 0, 1, 0);
    tick(1, 0, 0, 0);
    tick(1, 0, 1, 0);
    tick(0, 0, 1, 0);
    check("R9", "fall passes after cancel", sckFallGated, 1);
    tick(0, 0, 1, 0);
    check("R9", "no pause after cancel", pauseActive, 0);

    // R8: deselect clears a pause, and hold is ignored while deselected
    curReq = "R8";
    tick(0, 0, 0, 0);
    tick(0, 0, 0, 0);
    tick(0, 0, 0, 1);
    tick(0, 0, 0, 1);
    check("R8", "deselect clears pause", pauseActive, 0);
    tick(0, 0, 1, 1);
    tick(0, 0, 0, 1);
    tick(0, 0, 0, 1);
    check("R8", "no pause while deselected", pauseActive, 0);
    tick(0, 0, 1, 1);
    tick(0, 0, 1, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule